// File: doc/BRIEF.md
# DMA Request Issuer with Adaptive NACK Backoff

This block sits between a DMA engine and a request/response link. The engine hands it request packets through a push stream. The block holds them in a small transmit queue and issues them from the head of the queue onto a request channel. The link may refuse a request on the channel. It may also reject a request later by returning a negative acknowledgement (NACK) on the response port. A NACKed request comes back on the response port and is queued again ahead of all newer work.

The block adapts its issue rate with a backoff delay register. Every NACK raises the delay, either to the configured floor or by doubling it, and it stops growing once it reaches the configured ceiling. Every good response divides the delay by four. While the delay is zero, queued requests leave back to back. While it is nonzero, requests are spaced by a countdown. A refused request parks the issuer until the link raises its retry pulse.

A byte accumulator sums the sizes reported by good responses for the current transfer. It pulses done when the sum reaches the programmed total, and it pulses an error when the sum passes the total.

Top module: `dma_backoff_issuer`

Push stream rules: a packet transfers on a cycle where `push_valid` and `push_ready` are both high. `push_ready` is low whenever the queued packets plus the issued packets still awaiting a response fill `DEPTH`. It is also low on any cycle that carries a NACK response. Request channel rules: `req_valid` high with `req_ready` high is an accepted issue. `req_valid` high with `req_ready` low is a refusal. After a refusal, `req_valid` stays low until `link_retry` is seen.

## Requirements
- R1: On a NACK response, a backoff delay below `cfg_min_backoff` becomes `cfg_min_backoff`. A delay at or above the floor but below `cfg_max_backoff` doubles (shift left by one, kept to DLY_W bits). A delay at or above the ceiling is left unchanged. The new value shows on `backoff_delay` in the cycle after the response.
- R2: On a good response (`rsp_valid` high, `rsp_nack` low), the backoff delay is shifted right by two bit positions.
- R3: A NACKed packet (`rsp_pkt`) is inserted at the head of the transmit queue. It is issued before any packet that was already queued.
- R4: Every NACK reloads the backoff countdown with the new delay, even when a countdown is already running. With delay D loaded at the NACK's clock edge, the next issue is accepted D+1 edges later.
- R5: No request is presented while the countdown is running or while the block is waiting for a retry. The only exception is the single attempt made after a retry pulse (R8).
- R6: With a zero delay, queued packets are accepted on consecutive clock edges until the queue empties or the link refuses one.
- R7: With a nonzero delay D, an accepted issue that leaves packets in the queue starts the countdown. The next packet is then accepted D+1 edges after the previous one.
- R8: A refusal sets `retry_wait` and stops all attempts. A `link_retry` pulse while `retry_wait` is high makes the head packet be presented in the very next cycle, whether or not the countdown is running. An accepted attempt leaves `retry_wait` low.
- R9: `xfer_start` loads `xfer_total` and clears the byte sum. Each good response adds `rsp_bytes` to the sum. `xfer_done` pulses for one cycle, in the cycle after the response that makes the sum equal the total.
- R10: A good response that makes the sum exceed the total pulses `xfer_err` instead of `xfer_done`.
- R11: A push with `push_front` high goes to the head of the queue. A push with `push_front` low goes to the tail. `push_ready` is low while queued plus outstanding packets equal `DEPTH`.
- R12: After reset, `push_ready` is high, while `req_valid`, `retry_wait`, `xfer_done`, `xfer_err` and `backoff_delay` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_min_backoff | input | DLY_W | Backoff floor loaded by a NACK |
| cfg_max_backoff | input | DLY_W | Backoff ceiling for doubling |
| push_valid | input | 1 | Push stream valid |
| push_ready | output | 1 | Push stream ready |
| push_front | input | 1 | 1: insert at head, 0: insert at tail |
| push_pkt | input | PKT_W | Packet to queue |
| req_valid | output | 1 | Request presented to the link |
| req_ready | input | 1 | Link accepts the presented request |
| req_pkt | output | PKT_W | Presented request packet |
| link_retry | input | 1 | Link invites a new attempt after a refusal |
| rsp_valid | input | 1 | Response present |
| rsp_nack | input | 1 | Response is a negative acknowledgement |
| rsp_pkt | input | PKT_W | Rejected packet returned with a NACK |
| rsp_bytes | input | BYTES_W | Byte count carried by a good response |
| xfer_start | input | 1 | Begin a new transfer |
| xfer_total | input | BYTES_W | Byte total of the new transfer |
| xfer_done | output | 1 | One-cycle pulse: transfer complete |
| xfer_err | output | 1 | One-cycle pulse: byte sum exceeded total |
| backoff_delay | output | DLY_W | Current backoff delay |
| retry_wait | output | 1 | Waiting for a retry pulse from the link |

## Verification
The assertions check the delay arithmetic on every response: the floor, doubling and ceiling on a NACK, and the divide by four on a good response. On every cycle they also check that a NACK leaves the countdown running and suppresses the next attempt, that a refusal silences the channel, that a retry pulse yields an attempt in the next cycle, and that done pulses are single and never coincide with errors. Only the directed scenarios can show the order in which packets leave after front insertions and NACK requeues, the exact spacing of issues for a given delay, the reload of a countdown that is already running, and the byte totals that end a transfer or flag an overrun.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  typedef enum logic [1:0] {
    INS_NONE  = 2'd0,
    INS_BACK  = 2'd1,
    INS_FRONT = 2'd2
  } ins_op_e;
endpackage

// File: rtl/dbi_txq.sv
// Circular transmit queue with insertion at either end and pop at the head.
module dbi_txq
  import dbi_pkg::*;
#(
  parameter int PKT_W = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ins_op_e                      ins_op,
  input  logic [PKT_W-1:0]             ins_pkt,
  input  logic                         pop,
  output logic [PKT_W-1:0]             head_pkt,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PKT_W-1:0] slot_q [DEPTH];
  logic [IDX_W-1:0] head_q, head_d, tail_idx, wr_idx;
  logic [CNT_W-1:0] count_q, count_d;
  logic             wr_en;

  function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] idx_prev(input logic [IDX_W-1:0] p);
    return (p == '0) ? IDX_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  always_comb begin
    int t;
    t = int'(head_q) + int'(count_q);
    if (t >= DEPTH) t = t - DEPTH;
    tail_idx = IDX_W'(t);
  end

  always_comb begin
    head_d  = head_q;
    count_d = count_q;
    wr_en   = 1'b0;
    wr_idx  = head_q;
    unique case (ins_op)
      INS_FRONT: begin
        wr_en = 1'b1;
        if (pop) begin
          wr_idx = head_q;                 // replace the departing head in place
        end else begin
          wr_idx  = idx_prev(head_q);
          head_d  = idx_prev(head_q);
          count_d = count_q + 1'b1;
        end
      end
      INS_BACK: begin
        wr_en  = 1'b1;
        wr_idx = tail_idx;
        if (pop) head_d = idx_next(head_q);
        else     count_d = count_q + 1'b1;
      end
      default: begin
        if (pop) begin
          head_d  = idx_next(head_q);
          count_d = count_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= ins_pkt;
  end

  assign head_pkt = slot_q[head_q];
  assign count    = count_q;
endmodule

// File: rtl/dbi_backoff.sv
// Backoff delay register and the countdown that paces issues.
module dbi_backoff #(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] cfg_min,
  input  logic [DLY_W-1:0] cfg_max,
  input  logic             nack_evt,
  input  logic             good_evt,
  input  logic             arm,
  output logic [DLY_W-1:0] delay,
  output logic             busy
);
  logic [DLY_W-1:0] delay_q, delay_d, timer_q;

  always_comb begin
    delay_d = delay_q;
    if (nack_evt) begin
      if (delay_q < cfg_min)      delay_d = cfg_min;
      else if (delay_q < cfg_max) delay_d = {delay_q[DLY_W-2:0], 1'b0};
    end else if (good_evt) begin
      delay_d = delay_q >> 2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_q <= '0;
      timer_q <= '0;
    end else begin
      delay_q <= delay_d;
      if (nack_evt)             timer_q <= delay_d;   // restart with the new delay
      else if (arm)             timer_q <= delay_q;
      else if (timer_q != '0)   timer_q <= timer_q - 1'b1;
    end
  end

  assign delay = delay_q;
  assign busy  = (timer_q != '0);
endmodule

// File: rtl/dbi_xfer_acc.sv
// Per-transfer byte accumulator with completion and overrun pulses.
module dbi_xfer_acc #(
  parameter int BYTES_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BYTES_W-1:0] total,
  input  logic               add,
  input  logic [BYTES_W-1:0] bytes,
  output logic               done,
  output logic               err
);
  logic [BYTES_W-1:0] sum_q, total_q;
  logic               active_q, done_q, err_q;
  logic [BYTES_W:0]   sum_nx;

  assign sum_nx = {1'b0, sum_q} + {1'b0, bytes};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q    <= '0;
      total_q  <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start) begin
        sum_q    <= '0;
        total_q  <= total;
        active_q <= 1'b1;
      end else if (add && active_q) begin
        if (sum_nx == {1'b0, total_q}) begin
          done_q   <= 1'b1;
          active_q <= 1'b0;
        end else if (sum_nx > {1'b0, total_q}) begin
          err_q    <= 1'b1;
          active_q <= 1'b0;
        end else begin
          sum_q <= sum_nx[BYTES_W-1:0];
        end
      end
    end
  end

  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/dma_backoff_issuer.sv
module dma_backoff_issuer
  import dbi_pkg::*;
#(
  parameter int PKT_W   = 32,
  parameter int DEPTH   = 4,
  parameter int DLY_W   = 12,
  parameter int BYTES_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DLY_W-1:0]   cfg_min_backoff,
  input  logic [DLY_W-1:0]   cfg_max_backoff,
  input  logic               push_valid,
  output logic               push_ready,
  input  logic               push_front,
  input  logic [PKT_W-1:0]   push_pkt,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [PKT_W-1:0]   req_pkt,
  input  logic               link_retry,
  input  logic               rsp_valid,
  input  logic               rsp_nack,
  input  logic [PKT_W-1:0]   rsp_pkt,
  input  logic [BYTES_W-1:0] rsp_bytes,
  input  logic               xfer_start,
  input  logic [BYTES_W-1:0] xfer_total,
  output logic               xfer_done,
  output logic               xfer_err,
  output logic [DLY_W-1:0]   backoff_delay,
  output logic               retry_wait
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] q_count, outst_q, outst_d;
  logic [CNT_W:0]   occupancy;
  logic [PKT_W-1:0] head_pkt, ins_pkt;
  ins_op_e          ins_op;
  logic             nack_now, good_now, push_fire;
  logic             accept, refuse, arm;
  logic             await_q, kick_q, bo_busy;

  assign nack_now  = rsp_valid && rsp_nack;
  assign good_now  = rsp_valid && !rsp_nack;

  // Room is reserved for every outstanding packet so a NACK can always requeue.
  assign occupancy  = {1'b0, q_count} + {1'b0, outst_q};
  assign push_ready = !nack_now && (occupancy < (CNT_W+1)'(DEPTH));
  assign push_fire  = push_valid && push_ready;

  always_comb begin
    ins_op  = INS_NONE;
    ins_pkt = push_pkt;
    if (nack_now) begin
      ins_op  = INS_FRONT;
      ins_pkt = rsp_pkt;
    end else if (push_fire) begin
      ins_op = push_front ? INS_FRONT : INS_BACK;
    end
  end

  assign req_valid = (q_count != '0) && !await_q && (!bo_busy || kick_q);
  assign req_pkt   = head_pkt;
  assign accept    = req_valid && req_ready;
  assign refuse    = req_valid && !req_ready;
  assign arm       = accept && ((q_count > CNT_W'(1)) || (ins_op != INS_NONE));

  always_comb begin
    outst_d = outst_q;
    if (accept) outst_d = outst_d + 1'b1;
    if (rsp_valid && (outst_d != '0)) outst_d = outst_d - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      await_q <= 1'b0;
      kick_q  <= 1'b0;
      outst_q <= '0;
    end else begin
      outst_q <= outst_d;
      if (refuse)          await_q <= 1'b1;
      else if (link_retry) await_q <= 1'b0;
      if (req_valid)                  kick_q <= 1'b0;
      else if (link_retry && await_q) kick_q <= 1'b1;
    end
  end

  dbi_txq #(.PKT_W(PKT_W), .DEPTH(DEPTH)) u_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_op   (ins_op),
    .ins_pkt  (ins_pkt),
    .pop      (accept),
    .head_pkt (head_pkt),
    .count    (q_count)
  );

  dbi_backoff #(.DLY_W(DLY_W)) u_backoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_min  (cfg_min_backoff),
    .cfg_max  (cfg_max_backoff),
    .nack_evt (nack_now),
    .good_evt (good_now),
    .arm      (arm),
    .delay    (backoff_delay),
    .busy     (bo_busy)
  );

  dbi_xfer_acc #(.BYTES_W(BYTES_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (xfer_start),
    .total (xfer_total),
    .add   (good_now),
    .bytes (rsp_bytes),
    .done  (xfer_done),
    .err   (xfer_err)
  );

  assign retry_wait = await_q;
endmodule

// File: rtl/dbi_checker.sv
module dbi_checker #(
  parameter int DLY_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             link_retry,
  input logic             retry_wait,
  input logic             rsp_valid,
  input logic             rsp_nack,
  input logic [DLY_W-1:0] cfg_min,
  input logic [DLY_W-1:0] cfg_max,
  input logic [DLY_W-1:0] backoff_delay,
  input logic             bo_busy,
  input logic             xfer_done,
  input logic             xfer_err
);
  assert_nack_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nack && backoff_delay < cfg_min) |=> backoff_delay == $past(cfg_min));

  assert_nack_double_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nack && backoff_delay >= cfg_min && backoff_delay < cfg_max)
    |=> backoff_delay == DLY_W'($past(backoff_delay) << 1));

  assert_nack_ceiling_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nack && backoff_delay >= cfg_min && backoff_delay >= cfg_max)
    |=> $stable(backoff_delay));

  assert_good_quarter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_nack) |=> backoff_delay == ($past(backoff_delay) >> 2));

  assert_nack_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nack && cfg_min != '0) |=> bo_busy);

  assert_quiet_after_nack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nack && cfg_min != '0 && !link_retry) |=> !req_valid);

  assert_refusal_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (retry_wait && !req_valid));

  assert_retry_attempts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_wait && link_retry) |=> (req_valid && !retry_wait));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_done_err_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && xfer_err));
endmodule

bind dma_backoff_issuer dbi_checker #(.DLY_W(DLY_W)) u_dbi_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .link_retry    (link_retry),
  .retry_wait    (retry_wait),
  .rsp_valid     (rsp_valid),
  .rsp_nack      (rsp_nack),
  .cfg_min       (cfg_min_backoff),
  .cfg_max       (cfg_max_backoff),
  .backoff_delay (backoff_delay),
  .bo_busy       (bo_busy),
  .xfer_done     (xfer_done),
  .xfer_err      (xfer_err)
);

// File: tb/dma_backoff_issuer_bench.sv
module dma_backoff_issuer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PKT_W = 32, DEPTH = 4, DLY_W = 12, BYTES_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DLY_W-1:0] cfg_min_backoff = 12'd4, cfg_max_backoff = 12'd16;
  logic push_valid = 0, push_ready, push_front = 0;
  logic [PKT_W-1:0] push_pkt = '0, req_pkt, rsp_pkt = '0;
  logic req_valid, req_ready = 0, link_retry = 0;
  logic rsp_valid = 0, rsp_nack = 0;
  logic [BYTES_W-1:0] rsp_bytes = '0, xfer_total = '0;
  logic xfer_start = 0, xfer_done, xfer_err, retry_wait;
  logic [DLY_W-1:0] backoff_delay;

  int checks = 0, fails = 0, cyc = 0;
  int log_n = 0, nack_cyc = 0, retry_cyc = 0;
  logic [PKT_W-1:0] log_pkt [64];
  int log_cyc [64];

  dma_backoff_issuer #(.PKT_W(PKT_W), .DEPTH(DEPTH), .DLY_W(DLY_W), .BYTES_W(BYTES_W))
  u_dma_backoff_issuer (
    .clk(clk), .rst_n(rst_n),
    .cfg_min_backoff(cfg_min_backoff), .cfg_max_backoff(cfg_max_backoff),
    .push_valid(push_valid), .push_ready(push_ready), .push_front(push_front), .push_pkt(push_pkt),
    .req_valid(req_valid), .req_ready(req_ready), .req_pkt(req_pkt), .link_retry(link_retry),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_pkt(rsp_pkt), .rsp_bytes(rsp_bytes),
    .xfer_start(xfer_start), .xfer_total(xfer_total), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .backoff_delay(backoff_delay), .retry_wait(retry_wait)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Edge monitor: logs accepted issues, NACK edges and retry edges by cycle number.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && req_valid && req_ready) begin
      if (log_n < 64) begin
        log_pkt[log_n] <= req_pkt;
        log_cyc[log_n] <= cyc;
      end
      log_n <= log_n + 1;
    end
    if (rsp_valid && rsp_nack) nack_cyc <= cyc;
    if (link_retry) retry_cyc <= cyc;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push_one(input logic [PKT_W-1:0] p, input logic front);
    @(negedge clk);
    push_valid = 1'b1; push_pkt = p; push_front = front;
    #1;
    while (!push_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    push_valid = 1'b0; push_front = 1'b0;
  endtask

  task automatic respond(input logic nack, input logic [PKT_W-1:0] p, input logic [BYTES_W-1:0] b);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_nack = nack; rsp_pkt = p; rsp_bytes = b;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_nack = 1'b0;
    #1;
  endtask

  task automatic pulse_retry();
    @(negedge clk); link_retry = 1'b1;
    @(negedge clk); link_retry = 1'b0;
  endtask

  task automatic start_xfer(input logic [BYTES_W-1:0] t);
    @(negedge clk); xfer_start = 1'b1; xfer_total = t;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R12 push_ready", push_ready, 1);
    check("R12 req_valid", req_valid, 0);
    check("R12 retry_wait", retry_wait, 0);
    check("R12 backoff_delay", backoff_delay, 0);
    check("R12 done/err", {xfer_done, xfer_err}, 0);
  endtask

  // Refusal, retry, front/back insertion, zero-delay streaming.
  task automatic t_refuse_retry();
    int b = log_n;
    req_ready = 1'b0;
    push_one(32'h11, 1'b0);
    push_one(32'h22, 1'b0);
    push_one(32'h33, 1'b1);
    idle(2); #1;
    check("R8 retry_wait after refusal", retry_wait, 1);
    check("R5 no request while waiting", req_valid, 0);
    check("R5 nothing accepted", log_n - b, 0);
    req_ready = 1'b1;
    pulse_retry();
    idle(6); #1;
    check("R8 count after retry", log_n - b, 3);
    check("R11 front push leaves first", log_pkt[b], 32'h33);
    check("R11 back pushes follow", {log_pkt[b+1], log_pkt[b+2]}, {32'h11, 32'h22});
    check("R8 attempt right after retry", log_cyc[b] - retry_cyc, 1);
    check("R6 back to back 1", log_cyc[b+1] - log_cyc[b], 1);
    check("R6 back to back 2", log_cyc[b+2] - log_cyc[b+1], 1);
    check("R8 retry_wait cleared", retry_wait, 0);
  endtask

  // Delay growth to the ceiling and decay on good responses.
  task automatic t_growth_decay();
    int b = log_n;
    respond(1'b1, 32'h33, '0);
    check("R1 floor load", backoff_delay, 4);
    idle(10); #1;
    check("R3 requeued packet reissued", log_pkt[b], 32'h33);
    check("R4 reissue spacing", log_cyc[b] - nack_cyc, 5);
    respond(1'b1, 32'h33, '0);
    check("R1 double to 8", backoff_delay, 8);
    idle(20);
    respond(1'b1, 32'h33, '0);
    check("R1 double to 16", backoff_delay, 16);
    idle(20);
    respond(1'b1, 32'h33, '0);
    check("R1 ceiling holds", backoff_delay, 16);
    idle(20);
    respond(1'b0, '0, '0);
    check("R2 quarter 16", backoff_delay, 4);
    respond(1'b0, '0, '0);
    check("R2 quarter 4", backoff_delay, 1);
    respond(1'b0, '0, '0);
    check("R2 quarter 1", backoff_delay, 0);
  endtask

  // Paced issue with a nonzero delay and requeue order.
  task automatic t_pacing();
    int b;
    cfg_min_backoff = 12'd3;
    push_one(32'hA0, 1'b0);
    idle(3);
    b = log_n;
    respond(1'b1, 32'hA0, '0);
    check("R5 quiet during countdown", req_valid, 0);
    check("R1 floor 3", backoff_delay, 3);
    push_one(32'hB0, 1'b0);
    push_one(32'hC0, 1'b0);
    idle(20); #1;
    check("R3 order after nack", {log_pkt[b], log_pkt[b+1], log_pkt[b+2]}, {32'hA0, 32'hB0, 32'hC0});
    check("R7 first after nack", log_cyc[b] - nack_cyc, 4);
    check("R7 spacing B", log_cyc[b+1] - log_cyc[b], 4);
    check("R7 spacing C", log_cyc[b+2] - log_cyc[b+1], 4);
  endtask

  // A second NACK reloads a running countdown.
  task automatic t_restart();
    int b = log_n;
    respond(1'b1, 32'hA0, '0);
    check("R1 double to 6", backoff_delay, 6);
    respond(1'b1, 32'hB0, '0);
    check("R1 double to 12", backoff_delay, 12);
    idle(35); #1;
    check("R4 nothing before reload expiry", log_cyc[b] - nack_cyc, 13);
    check("R3 latest nack first", {log_pkt[b], log_pkt[b+1]}, {32'hB0, 32'hA0});
    check("R7 spacing 12", log_cyc[b+1] - log_cyc[b], 13);
    respond(1'b0, '0, '0);
    check("R2 quarter 12", backoff_delay, 3);
    respond(1'b0, '0, '0);
    respond(1'b0, '0, '0);
    check("R2 settles to zero", backoff_delay, 0);
  endtask

  task automatic t_bytes();
    start_xfer(16'd64);
    respond(1'b0, '0, 16'd16);
    check("R9 no early done 1", xfer_done, 0);
    respond(1'b0, '0, 16'd16);
    check("R9 no early done 2", xfer_done, 0);
    respond(1'b0, '0, 16'd32);
    check("R9 done at total", {xfer_done, xfer_err}, 2'b10);
    idle(1); #1;
    check("R9 done single pulse", xfer_done, 0);
    start_xfer(16'd40);
    respond(1'b0, '0, 16'd32);
    check("R10 no flag below total", {xfer_done, xfer_err}, 0);
    respond(1'b0, '0, 16'd16);
    check("R10 overrun flagged", {xfer_done, xfer_err}, 2'b01);
  endtask

  // Capacity reservation, and retry overriding a running countdown.
  task automatic t_capacity();
    int b;
    req_ready = 1'b1;
    push_one(32'h01, 1'b0);
    idle(3);
    req_ready = 1'b0;
    b = log_n;
    push_one(32'h02, 1'b0);
    push_one(32'h03, 1'b0);
    push_one(32'h04, 1'b0);
    #1;
    check("R11 full with outstanding", push_ready, 0);
    respond(1'b1, 32'h01, '0);
    check("R11 still full after requeue", push_ready, 0);
    req_ready = 1'b1;
    pulse_retry();
    idle(20); #1;
    check("R8 retry beats countdown", log_cyc[b] - retry_cyc, 1);
    check("R3 requeued first", log_pkt[b], 32'h01);
    check("R11 tail order", {log_pkt[b+1], log_pkt[b+2], log_pkt[b+3]}, {32'h02, 32'h03, 32'h04});
    check("R7 spacing after retry", log_cyc[b+1] - log_cyc[b], 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_refuse_retry();
    t_growth_decay();
    t_pacing();
    t_restart();
    t_bytes();
    t_capacity();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule